// File: doc/BRIEF.md
# Banked bit-addressable data memory

This unit is the on-chip data store of a small 8-bit controller. It holds 256 bytes of internal RAM and a compact file of special function registers (SFRs). Each clock it carries out one access command: a direct byte access, an indirect byte access through a pointer register, a stack push or pop, a working-register access through the active bank, or a single-bit read, set, clear or write.

The upper half of the byte address space is shared. A direct access to that range lands on the SFR file. An indirect access or a stack access to the same range lands on the upper RAM. One 8-bit bit address covers two areas: the bit-addressable RAM bytes, and those SFRs whose byte address is a multiple of eight. The status register is one of those SFRs. Its bank-select bits choose which RAM bytes the working registers map to, and it is always visible on a dedicated output.

Top module: `bitmem_unit`

## Requirements
- R1: A synchronous active-high reset sets rd_data to 0x00, the status register to 0x00 (bank 0) and the stack pointer to 0x07. The SFRs at 0x82, 0x83, 0xE0 and 0xF0 reset to 0x00. RAM contents are not reset.
- R2: cmd_kind selects one command per clock: 0 none, 1 direct read, 2 direct write, 3 indirect read, 4 indirect write, 5 register read, 6 register write, 7 push, 8 pop, 9 bit read, 10 bit set, 11 bit clear, 12 bit write, and 13 to 15 none. A read result is on rd_data after the edge that takes the command. On every command that is not a read, rd_data holds its value.
- R3: A direct access to 0x00–0x7F reaches RAM. A direct access to 0x80–0xFF reaches the SFR file, which implements 0x81 (stack pointer), 0x82, 0x83, 0xD0 (status), 0xE0 and 0xF0. A direct read of any other upper address returns 0x00, and a direct write to it changes no state.
- R4: An indirect access with cmd_addr[0]=s takes its pointer from RAM byte {3'b000, bank, 2'b00, s}. It then reaches the RAM byte at that pointer across the whole range 0x00–0xFF, and never an SFR.
- R5: A register access to Rn, with n = cmd_addr[2:0], reaches RAM byte {3'b000, bank, n}, where bank = status[4:3].
- R6: A push first increments the stack pointer and then writes cmd_wdata to RAM at the new value. A pop first puts RAM at the stack pointer on rd_data and then decrements the pointer. The pointer wraps modulo 256, and stack accesses always reach RAM.
- R7: A bit address b below 0x80 selects bit b[2:0] of RAM byte 0x20 + b[6:3]. A bit address of 0x80 or above selects bit b[2:0] of SFR {b[7:3], 3'b000}. A bit read returns {7'b0, bit}.
- R8: A bit set, clear or write (the last takes its value from cmd_bit) changes only the selected bit, as a read-modify-write within one clock. A bit operation on an unimplemented SFR reads 0 and changes no state.
- R9: In the status register, bit 7 is the carry (bit address 0xD7) and bits 4:3 are the bank select (bit addresses 0xD4 and 0xD3). A bank change made by a bit operation or by a direct write applies to the very next command.
- R10: stat_out shows the status register after every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_kind | input | 4 | Access kind code (R2) |
| cmd_addr | input | 8 | Byte address, bit address, pointer select or register number |
| cmd_wdata | input | 8 | Byte write data and push data |
| cmd_bit | input | 1 | Value for a bit write |
| rd_data | output | 8 | Registered read result |
| stat_out | output | 8 | Status register contents |

## Verification
Two pieces of work share a single cycle. An indirect access reads its pointer from the banked register area and accesses the pointed-to byte in the same clock. A bit operation reads, modifies and writes back its containing byte in one clock. The bench provokes the interaction between them in two ways. It changes the bank through a status bit operation and issues a register or indirect access in the very next cycle. It also points a pointer at an address in the upper range and at the same time places a different value in the SFR that shares that address. A behavioural model predicts rd_data and stat_out on every clock, and any divergence is reported. Directed cases cover stack wrap-around and unimplemented SFRs, and a long random phase mixes all command kinds.

// File: rtl/bitmem_pkg.sv
`timescale 1ns/1ps
package bitmem_pkg;

  localparam int AW = 8;
  localparam int DW = 8;

  typedef enum logic [3:0] {
    K_NOP  = 4'd0,
    K_DRD  = 4'd1,
    K_DWR  = 4'd2,
    K_IRD  = 4'd3,
    K_IWR  = 4'd4,
    K_RRD  = 4'd5,
    K_RWR  = 4'd6,
    K_PUSH = 4'd7,
    K_POP  = 4'd8,
    K_BRD  = 4'd9,
    K_BSET = 4'd10,
    K_BCLR = 4'd11,
    K_BWR  = 4'd12
  } acc_kind_e;

  // implemented special registers
  localparam int NUM_SFR  = 6;
  localparam int SFR_STK  = 0;
  localparam int SFR_STAT = 3;

  function automatic logic [7:0] sfr_addr(input int idx);
    case (idx)
      0:       return 8'h81;
      1:       return 8'h82;
      2:       return 8'h83;
      3:       return 8'hD0;
      4:       return 8'hE0;
      default: return 8'hF0;
    endcase
  endfunction

  function automatic logic [7:0] sfr_rst(input int idx);
    return (idx == SFR_STK) ? 8'h07 : 8'h00;
  endfunction

  typedef struct packed {
    logic       to_sfr;
    logic [7:0] byte_addr;
    logic [2:0] bit_idx;
    logic       bit_op;
    logic       wr_en;
    logic       rd_en;
    logic       stk_en;
    logic [7:0] stk_val;
  } route_t;

endpackage

// File: rtl/bitmem_route.sv
`timescale 1ns/1ps
module bitmem_route
  import bitmem_pkg::*;
(
  input  acc_kind_e  kind,
  input  logic [7:0] addr,
  input  logic [1:0] bank,
  input  logic [7:0] ptr_val,
  input  logic [7:0] sp,
  output logic [7:0] ptr_addr,
  output route_t     route
);

  logic [7:0] bit_byte;

  // pointer register of the active bank, selected by addr[0]
  assign ptr_addr = {3'b000, bank, 2'b00, addr[0]};
  assign bit_byte = addr[7] ? {addr[7:3], 3'b000} : {4'h2, addr[6:3]};

  always_comb begin
    route           = '0;
    route.byte_addr = addr;
    unique case (kind)
      K_DRD: begin
        route.to_sfr = addr[7];
        route.rd_en  = 1'b1;
      end
      K_DWR: begin
        route.to_sfr = addr[7];
        route.wr_en  = 1'b1;
      end
      K_IRD: begin
        route.byte_addr = ptr_val;
        route.rd_en     = 1'b1;
      end
      K_IWR: begin
        route.byte_addr = ptr_val;
        route.wr_en     = 1'b1;
      end
      K_RRD: begin
        route.byte_addr = {3'b000, bank, addr[2:0]};
        route.rd_en     = 1'b1;
      end
      K_RWR: begin
        route.byte_addr = {3'b000, bank, addr[2:0]};
        route.wr_en     = 1'b1;
      end
      K_PUSH: begin
        route.byte_addr = sp + 8'd1;
        route.wr_en     = 1'b1;
        route.stk_en    = 1'b1;
        route.stk_val   = sp + 8'd1;
      end
      K_POP: begin
        route.byte_addr = sp;
        route.rd_en     = 1'b1;
        route.stk_en    = 1'b1;
        route.stk_val   = sp - 8'd1;
      end
      K_BRD: begin
        route.to_sfr    = addr[7];
        route.byte_addr = bit_byte;
        route.bit_idx   = addr[2:0];
        route.bit_op    = 1'b1;
        route.rd_en     = 1'b1;
      end
      K_BSET, K_BCLR, K_BWR: begin
        route.to_sfr    = addr[7];
        route.byte_addr = bit_byte;
        route.bit_idx   = addr[2:0];
        route.bit_op    = 1'b1;
        route.wr_en     = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/bitmem_bitop.sv
`timescale 1ns/1ps
module bitmem_bitop
  import bitmem_pkg::*;
#(
  parameter int W  = DW,
  localparam int IW = $clog2(W)
) (
  input  acc_kind_e       kind,
  input  logic [W-1:0]    cur,
  input  logic [IW-1:0]   idx,
  input  logic            bitv,
  output logic [W-1:0]    new_byte,
  output logic            bit_val
);

  assign bit_val = cur[idx];

  always_comb begin
    new_byte = cur;
    case (kind)
      K_BSET:  new_byte[idx] = 1'b1;
      K_BCLR:  new_byte[idx] = 1'b0;
      K_BWR:   new_byte[idx] = bitv;
      default: ;
    endcase
  end

endmodule

// File: rtl/bitmem_ram.sv
`timescale 1ns/1ps
module bitmem_ram #(
  parameter int AW_P = 8,
  parameter int DW_P = 8,
  localparam int DEPTH = 1 << AW_P
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW_P-1:0] waddr,
  input  logic [DW_P-1:0] wdata,
  input  logic [AW_P-1:0] raddr_a,
  output logic [DW_P-1:0] rdata_a,
  input  logic [AW_P-1:0] raddr_b,
  output logic [DW_P-1:0] rdata_b
);

  logic [DW_P-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/bitmem_sfr.sv
`timescale 1ns/1ps
module bitmem_sfr
  import bitmem_pkg::*;
#(
  parameter int NUM = NUM_SFR,
  parameter int W   = DW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [7:0]   addr,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         stk_we,
  input  logic [W-1:0] stk_val,
  output logic [W-1:0] rdata,
  output logic [W-1:0] stk_q,
  output logic [W-1:0] stat_q
);

  logic [NUM-1:0]        hit;
  logic [NUM-1:0][W-1:0] regs;

  for (genvar i = 0; i < NUM; i++) begin : g_reg
    logic [W-1:0] q;
    assign hit[i]  = (addr == sfr_addr(i));
    assign regs[i] = q;
    always_ff @(posedge clk) begin
      if (rst)                            q <= W'(sfr_rst(i));
      else if (we && hit[i])              q <= wdata;
      else if ((i == SFR_STK) && stk_we)  q <= stk_val;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM; i++) begin
      if (hit[i]) rdata = rdata | regs[i];
    end
  end

  assign stk_q  = regs[SFR_STK];
  assign stat_q = regs[SFR_STAT];

endmodule

// File: rtl/bitmem_unit.sv
`timescale 1ns/1ps
module bitmem_unit
  import bitmem_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    cmd_kind,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          cmd_bit,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] stat_out
);

  acc_kind_e     kind;
  route_t        route;
  logic [AW-1:0] ptr_addr;
  logic [DW-1:0] ptr_val;
  logic [DW-1:0] ram_rd;
  logic [DW-1:0] sfr_rd;
  logic [DW-1:0] stk_q;
  logic [DW-1:0] stat_q;
  logic [DW-1:0] cur_byte;
  logic [DW-1:0] new_byte;
  logic [DW-1:0] wr_byte;
  logic          bit_val;
  logic [DW-1:0] rd_q;

  assign kind = acc_kind_e'(cmd_kind);

  bitmem_route u_route (
    .kind     (kind),
    .addr     (cmd_addr),
    .bank     (stat_q[4:3]),
    .ptr_val  (ptr_val),
    .sp       (stk_q),
    .ptr_addr (ptr_addr),
    .route    (route)
  );

  bitmem_ram #(.AW_P(AW), .DW_P(DW)) u_ram (
    .clk     (clk),
    .we      (route.wr_en & ~route.to_sfr),
    .waddr   (route.byte_addr),
    .wdata   (wr_byte),
    .raddr_a (ptr_addr),
    .rdata_a (ptr_val),
    .raddr_b (route.byte_addr),
    .rdata_b (ram_rd)
  );

  bitmem_sfr #(.NUM(NUM_SFR), .W(DW)) u_sfr (
    .clk     (clk),
    .rst     (rst),
    .addr    (route.byte_addr),
    .we      (route.wr_en & route.to_sfr),
    .wdata   (wr_byte),
    .stk_we  (route.stk_en),
    .stk_val (route.stk_val),
    .rdata   (sfr_rd),
    .stk_q   (stk_q),
    .stat_q  (stat_q)
  );

  assign cur_byte = route.to_sfr ? sfr_rd : ram_rd;

  bitmem_bitop #(.W(DW)) u_bitop (
    .kind     (kind),
    .cur      (cur_byte),
    .idx      (route.bit_idx),
    .bitv     (cmd_bit),
    .new_byte (new_byte),
    .bit_val  (bit_val)
  );

  assign wr_byte = route.bit_op ? new_byte : cmd_wdata;

  always_ff @(posedge clk) begin
    if (rst)              rd_q <= '0;
    else if (route.rd_en) rd_q <= route.bit_op ? {{(DW-1){1'b0}}, bit_val} : cur_byte;
  end

  assign rd_data  = rd_q;
  assign stat_out = stat_q;

endmodule

// File: rtl/bitmem_chk.sv
`timescale 1ns/1ps
module bitmem_chk
  import bitmem_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [3:0] cmd_kind,
  input logic [7:0] cmd_addr,
  input logic [7:0] rd_data,
  input logic [7:0] stat_out,
  input logic [7:0] stk_q
);

  p_reset_vals_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == 8'h00 && stat_out == 8'h00 && stk_q == 8'h07));

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_kind inside {K_NOP, K_DWR, K_IWR, K_RWR, K_PUSH, K_BSET, K_BCLR, K_BWR})
    |=> $stable(rd_data));

  p_unimpl_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_kind == K_DRD && cmd_addr == 8'h84) |=> (rd_data == 8'h00));

  p_push_inc_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_kind == K_PUSH) |=> (stk_q == $past(stk_q) + 8'd1));

  p_pop_dec_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_kind == K_POP) |=> (stk_q == $past(stk_q) - 8'd1));

  p_bitrd_narrow_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_kind == K_BRD) |=> (rd_data[7:1] == 7'd0));

  p_bitset_stat_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_kind == K_BSET && cmd_addr[7:3] == 5'h1A) |=> stat_out[$past(cmd_addr[2:0])]);

  p_bit_others_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_kind inside {K_BSET, K_BCLR, K_BWR} && cmd_addr[7:3] == 5'h1A)
    |=> (((stat_out ^ $past(stat_out)) & ~(8'd1 << $past(cmd_addr[2:0]))) == 8'd0));

  p_stat_direct_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_kind == K_DWR && cmd_addr != 8'hD0) |=> $stable(stat_out));

endmodule

bind bitmem_unit bitmem_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_kind (cmd_kind),
  .cmd_addr (cmd_addr),
  .rd_data  (rd_data),
  .stat_out (stat_out),
  .stk_q    (stk_q)
);

// File: tb/bitmem_unit_tb.sv
`timescale 1ns/1ps
module bitmem_unit_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cmd_kind = 4'd0;
  logic [7:0] cmd_addr = 8'd0;
  logic [7:0] cmd_wdata = 8'd0;
  logic       cmd_bit = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] stat_out;

  int total = 0;
  int bad   = 0;

  // reference model state
  logic [7:0] m_ram [256];
  logic [7:0] m_sp, m_stat, m_dl, m_dh, m_acc, m_aux;
  logic [7:0] exp_rd;
  string      ptag;

  always #2.5 clk = ~clk;

  bitmem_unit u_dut (
    .clk       (clk),
    .rst       (rst),
    .cmd_kind  (cmd_kind),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .cmd_bit   (cmd_bit),
    .rd_data   (rd_data),
    .stat_out  (stat_out)
  );

  function automatic logic [7:0] m_sfr_rd(input logic [7:0] a);
    case (a)
      8'h81:   return m_sp;
      8'h82:   return m_dl;
      8'h83:   return m_dh;
      8'hD0:   return m_stat;
      8'hE0:   return m_acc;
      8'hF0:   return m_aux;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_sfr_wr(input logic [7:0] a, input logic [7:0] v);
    case (a)
      8'h81:   m_sp   = v;
      8'h82:   m_dl   = v;
      8'h83:   m_dh   = v;
      8'hD0:   m_stat = v;
      8'hE0:   m_acc  = v;
      8'hF0:   m_aux  = v;
      default: ;
    endcase
  endtask

  function automatic string kind2tag(input int k);
    case (k)
      1, 2:          return "R3";
      3, 4:          return "R4";
      5, 6:          return "R5";
      7, 8:          return "R6";
      9:             return "R7";
      10, 11, 12:    return "R8";
      default:       return "R2";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare outputs of the previous command, then issue a new one
  task automatic step(input int k, input logic [7:0] a, input logic [7:0] wd,
                      input logic bv, input string tag);
    logic [1:0] bank;
    logic [7:0] p, ba, cur, nb;
    int         i;
    @(negedge clk);
    chk(rd_data === exp_rd, ptag, rd_data, exp_rd);
    chk(stat_out === m_stat, "R10", stat_out, m_stat);
    cmd_kind  = k[3:0];
    cmd_addr  = a;
    cmd_wdata = wd;
    cmd_bit   = bv;
    ptag      = (tag != "") ? tag : kind2tag(k);
    bank      = m_stat[4:3];
    p         = m_ram[{3'b000, bank, 2'b00, a[0]}];
    ba        = a[7] ? {a[7:3], 3'b000} : (8'h20 + {4'h0, a[6:3]});
    cur       = a[7] ? m_sfr_rd(ba) : m_ram[ba];
    i         = int'(a[2:0]);
    case (k)
      1: exp_rd = a[7] ? m_sfr_rd(a) : m_ram[a];
      2: if (a[7]) m_sfr_wr(a, wd); else m_ram[a] = wd;
      3: exp_rd = m_ram[p];
      4: m_ram[p] = wd;
      5: exp_rd = m_ram[{3'b000, bank, a[2:0]}];
      6: m_ram[{3'b000, bank, a[2:0]}] = wd;
      7: begin m_sp = m_sp + 8'd1; m_ram[m_sp] = wd; end
      8: begin exp_rd = m_ram[m_sp]; m_sp = m_sp - 8'd1; end
      9: exp_rd = {7'd0, cur[i]};
      10, 11, 12: begin
        nb    = cur;
        nb[i] = (k == 10) ? 1'b1 : (k == 11) ? 1'b0 : bv;
        if (a[7]) m_sfr_wr(ba, nb); else m_ram[ba] = nb;
      end
      default: ;
    endcase
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_sp = 8'h07; m_stat = 8'h00; m_dl = 8'h00; m_dh = 8'h00; m_acc = 8'h00; m_aux = 8'h00;
    exp_rd = 8'h00;
    ptag   = "R1";
    for (int a = 0; a < 256; a++) m_ram[a] = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset values, read back the stack pointer and an SFR
    step(1, 8'h81, 8'h00, 1'b0, "R1");
    step(1, 8'hE0, 8'h00, 1'b0, "R1");
    step(1, 8'h82, 8'h00, 1'b0, "R1");

    // fill all of RAM so every later read is predictable
    for (int a = 0; a < 128; a++) step(2, 8'(a), 8'(a * 7 + 3), 1'b0, "");
    for (int a = 128; a < 256; a++) begin
      step(2, 8'h00, 8'(a), 1'b0, "");
      step(4, 8'h00, 8'(a * 5 + 1), 1'b0, "");
    end

    // R3 vs R4: same upper address, SFR on direct, RAM on indirect
    step(2, 8'hE0, 8'h5A, 1'b0, "R3");
    step(2, 8'h01, 8'hE0, 1'b0, "R4");
    step(3, 8'h01, 8'h00, 1'b0, "R4");
    step(1, 8'hE0, 8'h00, 1'b0, "R3");
    step(4, 8'h01, 8'hC3, 1'b0, "R4");
    step(1, 8'hE0, 8'h00, 1'b0, "R3");
    step(3, 8'h01, 8'h00, 1'b0, "R4");
    // R3: unimplemented SFR ignores writes, reads zero
    step(2, 8'h84, 8'hFF, 1'b0, "R3");
    step(1, 8'h84, 8'h00, 1'b0, "R3");

    // R9 / R5: bank change by bit op applies to the next command
    step(2, 8'h10, 8'h77, 1'b0, "R5");
    step(10, 8'hD4, 8'h00, 1'b0, "R9");
    step(5, 8'h00, 8'h00, 1'b0, "R9");
    step(6, 8'h03, 8'h3C, 1'b0, "R5");
    step(1, 8'h13, 8'h00, 1'b0, "R5");
    step(11, 8'hD4, 8'h00, 1'b0, "R9");
    step(5, 8'h00, 8'h00, 1'b0, "R9");
    step(2, 8'hD0, 8'h08, 1'b0, "R9");
    step(3, 8'h00, 8'h00, 1'b0, "R9");
    step(2, 8'hD0, 8'h00, 1'b0, "R9");
    step(10, 8'hD7, 8'h00, 1'b0, "R9");

    // R6: stack wrap-around both ways
    step(2, 8'h81, 8'hFE, 1'b0, "R6");
    step(7, 8'h00, 8'hA1, 1'b0, "R6");
    step(7, 8'h00, 8'hA2, 1'b0, "R6");
    step(1, 8'h81, 8'h00, 1'b0, "R6");
    step(8, 8'h00, 8'h00, 1'b0, "R6");
    step(8, 8'h00, 8'h00, 1'b0, "R6");
    step(1, 8'h81, 8'h00, 1'b0, "R6");
    step(1, 8'hFF, 8'h00, 1'b0, "R6");

    // R7 / R8: RAM bit area and SFR bits
    step(12, 8'h00, 8'h00, 1'b1, "R8");
    step(9, 8'h00, 8'h00, 1'b0, "R7");
    step(11, 8'h7F, 8'h00, 1'b0, "R8");
    step(1, 8'h2F, 8'h00, 1'b0, "R8");
    step(10, 8'h88, 8'h00, 1'b0, "R8");
    step(9, 8'h88, 8'h00, 1'b0, "R8");
    step(10, 8'hE5, 8'h00, 1'b0, "R8");
    step(1, 8'hE0, 8'h00, 1'b0, "R8");
    step(9, 8'hF3, 8'h00, 1'b0, "R7");
    step(0, 8'h00, 8'h00, 1'b0, "R2");

    // random mix of every command kind
    for (int n = 0; n < 4000; n++) begin
      int          k;
      logic [7:0]  a;
      k = int'($urandom_range(0, 15));
      a = 8'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        case ($urandom_range(0, 5))
          0: a = 8'h81; 1: a = 8'h82; 2: a = 8'hD0; 3: a = 8'hE0; 4: a = 8'hF0;
          default: a = 8'hD0 | 8'($urandom_range(0, 7));
        endcase
      end
      step(k, a, 8'($urandom), 1'($urandom), "");
    end
    step(0, 8'h00, 8'h00, 1'b0, "R2");
    step(0, 8'h00, 8'h00, 1'b0, "R2");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule